// File: doc/BRIEF.md
# External/Status Change Interrupt Latch

This block watches six slow status inputs for each of two serial channels and turns any change on them into an interrupt for the host. The six are break/abort, transmit underrun/end-of-message, clear-to-send, sync/hunt, carrier detect and baud-counter zero count. Each input passes through a two-flop synchronizer. A per-channel snapshot follows the synchronized values until an enabled input changes in either direction. The block then raises a pending flag and freezes the snapshot, so the host reads the values that caused the request.

The host sees the snapshot in a status byte per channel. That byte also carries two live bits, transmit-buffer-empty and receive-character-available. Those two bits are passed straight through and never raise a request. The host re-arms a channel by writing the reset-status command to its command register. If the inputs moved while the snapshot was frozen, a fresh request follows at once.

Three write registers gate the requests:
- a per-channel source-enable byte;
- a per-channel enable bit;
- one master enable shared by both channels.

The pending flags of both channels appear in a combined interrupt-pending byte.

Top module: `extstat_latch`

## Requirements
- R1: After reset, the latched bits of both status bytes are 0, the pending byte is 0x00 and `irq_o` is low.
- R2: Status byte layout: bit 7 break/abort, bit 6 underrun/EOM, bit 5 CTS, bit 4 sync/hunt, bit 3 DCD, bit 2 transmit empty, bit 1 zero count, bit 0 receive available. The external input vector per channel is ordered [5] break, [4] underrun, [3] CTS, [2] sync/hunt, [1] DCD, [0] zero count. Channel A uses `ext_i[5:0]` and channel B uses `ext_i[11:6]`.
- R3: Status bits 2 and 0 follow `tx_empty_i` and `rx_avail_i` of that channel in the same cycle, and they never set a pending flag.
- R4: While a channel is not pending, a change in either direction of an enabled input sets the pending flag. The change must be present in the synchronized value and must differ from the snapshot.
- R5: The source-enable register (address 15) enables sources as follows: bit 7 break, bit 6 underrun, bit 5 CTS, bit 4 sync/hunt, bit 3 DCD, bit 1 zero count. Bits 2 and 0 are ignored. A disabled source still updates the snapshot but raises no request.
- R6: While a channel is pending, its latched status bits (7..3 and 1) hold their value whatever the inputs do.
- R7: A write to address 0 whose bits 5..3 equal 3'b010 clears that channel's pending flag at the next edge. The snapshot then resumes tracking, and a new request is raised if the synchronized inputs differ from the old snapshot. Other command codes, and the command sent to the other channel, leave the flag set.
- R8: Address 1 bit 0 is the channel's enable. While it is 0, no new pending flag is set on that channel.
- R9: Address 9 bit 3 is the master enable, shared: a write through either channel sets it. `irq_o` is high exactly when the master enable is set and some channel is pending with its channel enable set.
- R10: The pending byte shows channel A at bit 3 and channel B at bit 0. All its other bits read 0.
- R11: An input change becomes visible in the snapshot and the pending flag on the third rising edge after it is applied, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_chan_i | input | 1 | Channel of the write (0 = A, 1 = B) |
| wr_addr_i | input | 4 | Write register address |
| wr_data_i | input | 8 | Write data |
| ext_i | input | 12 | Raw status inputs, channel A in [5:0], channel B in [11:6] |
| tx_empty_i | input | 2 | Live transmit-empty per channel |
| rx_avail_i | input | 2 | Live receive-available per channel |
| rr0_a_o | output | 8 | Status byte, channel A |
| rr0_b_o | output | 8 | Status byte, channel B |
| rr3_o | output | 8 | Combined pending byte |
| irq_o | output | 1 | Interrupt request |

## Verification
A snapshot that fails to freeze shows up in the status byte within one cycle of the next input change on a pending channel. A lost or stuck pending flag shows in the pending byte and on `irq_o` three edges after the triggering input change, or one edge after the reset command. A synchronizer that is one stage short moves every visible update one edge earlier, so the bench samples the exact edge at which each change appears. A cycle-level model in the bench compares all outputs on every cycle of a random run.

// File: rtl/extstat_pkg.sv
package extstat_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_W   = 1;
    localparam int SRC_W  = 6;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] REG_CMD    = 4'd0;
    localparam logic [ADDR_W-1:0] REG_IRQCTL = 4'd1;
    localparam logic [ADDR_W-1:0] REG_MASTER = 4'd9;
    localparam logic [ADDR_W-1:0] REG_SRCEN  = 4'd15;

    localparam logic [2:0] CMD_RESET_EXT = 3'b010;

    typedef logic [SRC_W-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t snap;
        logic     pend;
    } chan_state_t;

    typedef struct packed {
        logic [NUM_CH-1:0][SRC_W-1:0] en;
        logic [NUM_CH-1:0]            ie;
        logic                         mie;
    } cfg_state_t;

    // Source-enable byte to internal source order; bits 2 and 0 dropped.
    function automatic src_vec_t srcen_decode(input logic [DATA_W-1:0] b);
        return {b[7], b[6], b[5], b[4], b[3], b[1]};
    endfunction

    // Status byte from snapshot and the two live bits.
    function automatic logic [DATA_W-1:0] status_pack(input src_vec_t snap,
                                                      input logic txe,
                                                      input logic rxa);
        return {snap[5:1], txe, snap[0], rxa};
    endfunction
endpackage

// File: rtl/extstat_sync.sv
module extstat_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/extstat_cfg.sv
module extstat_cfg
    import extstat_pkg::*;
(
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_en_i,
    input  logic [CH_W-1:0]               wr_chan_i,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    output logic [NUM_CH-1:0][SRC_W-1:0]  src_en_o,
    output logic [NUM_CH-1:0]             chan_ie_o,
    output logic                          master_ie_o,
    output logic [NUM_CH-1:0]             clr_o
);
    cfg_state_t        cfg_d, cfg_q;
    logic [NUM_CH-1:0] clr_d;
    logic              unused_bit2;

    assign unused_bit2 = wr_data_i[2];

    always_comb begin
        cfg_d = cfg_q;
        clr_d = '0;
        if (wr_en_i) begin
            case (wr_addr_i)
                REG_CMD:    if (wr_data_i[5:3] == CMD_RESET_EXT) clr_d[wr_chan_i] = 1'b1;
                REG_IRQCTL: cfg_d.ie[wr_chan_i] = wr_data_i[0];
                REG_MASTER: cfg_d.mie = wr_data_i[3];
                REG_SRCEN:  cfg_d.en[wr_chan_i] = srcen_decode(wr_data_i);
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign src_en_o    = cfg_q.en;
    assign chan_ie_o   = cfg_q.ie;
    assign master_ie_o = cfg_q.mie;
    assign clr_o       = clr_d;
endmodule

// File: rtl/extstat_chan.sv
module extstat_chan
    import extstat_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  src_vec_t sync_i,
    input  src_vec_t en_i,
    input  logic     ie_i,
    input  logic     clr_i,
    output src_vec_t snap_o,
    output logic     pend_o
);
    chan_state_t st_d, st_q;
    src_vec_t    diff;
    logic        raise;

    always_comb begin
        st_d  = st_q;
        diff  = sync_i ^ st_q.snap;
        raise = ie_i && ((diff & en_i) != '0);
        if (st_q.pend) begin
            // frozen: only the reset command releases it
            if (clr_i) st_d.pend = 1'b0;
        end else begin
            st_d.snap = sync_i;
            st_d.pend = raise;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign snap_o = st_q.snap;
    assign pend_o = st_q.pend;
endmodule

// File: rtl/extstat_latch.sv
module extstat_latch
    import extstat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_en_i,
    input  logic                      wr_chan_i,
    input  logic [ADDR_W-1:0]         wr_addr_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    input  logic [NUM_CH*SRC_W-1:0]   ext_i,
    input  logic [NUM_CH-1:0]         tx_empty_i,
    input  logic [NUM_CH-1:0]         rx_avail_i,
    output logic [DATA_W-1:0]         rr0_a_o,
    output logic [DATA_W-1:0]         rr0_b_o,
    output logic [DATA_W-1:0]         rr3_o,
    output logic                      irq_o
);
    logic [NUM_CH-1:0][SRC_W-1:0]  src_en;
    logic [NUM_CH-1:0]             chan_ie;
    logic                          master_ie;
    logic [NUM_CH-1:0]             clr_cmd;
    logic [NUM_CH-1:0][SRC_W-1:0]  sync_src;
    logic [NUM_CH-1:0][SRC_W-1:0]  snap;
    logic [NUM_CH-1:0]             chan_pend;
    logic [NUM_CH-1:0][DATA_W-1:0] rr0_all;

    extstat_cfg i_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .wr_chan_i   (wr_chan_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .src_en_o    (src_en),
        .chan_ie_o   (chan_ie),
        .master_ie_o (master_ie),
        .clr_o       (clr_cmd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        extstat_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) i_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .d_i    (ext_i[c*SRC_W +: SRC_W]),
            .q_o    (sync_src[c])
        );

        extstat_chan i_chan (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .sync_i (sync_src[c]),
            .en_i   (src_en[c]),
            .ie_i   (chan_ie[c]),
            .clr_i  (clr_cmd[c]),
            .snap_o (snap[c]),
            .pend_o (chan_pend[c])
        );

        assign rr0_all[c] = status_pack(snap[c], tx_empty_i[c], rx_avail_i[c]);
    end

    assign rr0_a_o = rr0_all[0];
    assign rr0_b_o = rr0_all[1];
    // pending byte: channel A at bit 3, channel B at bit 0
    assign rr3_o   = {4'b0000, chan_pend[0], 2'b00, chan_pend[1]};
    assign irq_o   = master_ie & ((chan_pend & chan_ie) != '0);
endmodule

// File: rtl/extstat_latch_chk.sv
module extstat_latch_chk
    import extstat_pkg::*;
(
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic [NUM_CH-1:0][DATA_W-1:0] rr0_all,
    input logic [DATA_W-1:0]         rr3_o,
    input logic                      irq_o,
    input logic [NUM_CH-1:0]         chan_ie,
    input logic                      master_ie,
    input logic [NUM_CH-1:0]         clr_cmd
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam int PB = (c == 0) ? 3 : 0;

        assert_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rr3_o[PB] |=> (rr0_all[c][7:3] == $past(rr0_all[c][7:3]) &&
                           rr0_all[c][1]   == $past(rr0_all[c][1])));

        assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_cmd[c] && rr3_o[PB]) |=> !rr3_o[PB]);

        assert_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(rr3_o[PB]) |-> $past(chan_ie[c]));

        assert_raise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(rr3_o[PB]) |-> ({rr0_all[c][7:3], rr0_all[c][1]} !=
                                  $past({rr0_all[c][7:3], rr0_all[c][1]})));
    end

    assert_irq_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (master_ie && (rr3_o[3] || rr3_o[0])));
endmodule

bind extstat_latch extstat_latch_chk i_extstat_latch_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rr0_all   (rr0_all),
    .rr3_o     (rr3_o),
    .irq_o     (irq_o),
    .chan_ie   (chan_ie),
    .master_ie (master_ie),
    .clr_cmd   (clr_cmd)
);

// File: tb/test_extstat_latch.sv
module test_extstat_latch;
    logic        clk_i = 1'b0;
    logic        rst_ni;
    logic        wr_en_i;
    logic        wr_chan_i;
    logic [3:0]  wr_addr_i;
    logic [7:0]  wr_data_i;
    logic [11:0] ext_i;
    logic [1:0]  tx_empty_i;
    logic [1:0]  rx_avail_i;
    logic [7:0]  rr0_a_o, rr0_b_o, rr3_o;
    logic        irq_o;

    int errors = 0;
    int checks = 0;

    // bench model
    logic [5:0] m_s1 [2];
    logic [5:0] m_s2 [2];
    logic [5:0] m_snap [2];
    logic       m_pend [2];
    logic [5:0] m_en [2];
    logic       m_ie [2];
    logic       m_mie;

    always #10 clk_i = ~clk_i;

    extstat_latch i_extstat_latch (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_chan_i(wr_chan_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .ext_i(ext_i),
        .tx_empty_i(tx_empty_i), .rx_avail_i(rx_avail_i),
        .rr0_a_o(rr0_a_o), .rr0_b_o(rr0_b_o), .rr3_o(rr3_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_rr0(input int c);
        return {m_snap[c][5:1], tx_empty_i[c], m_snap[c][0], rx_avail_i[c]};
    endfunction

    function automatic logic [7:0] exp_rr3();
        return {4'b0000, m_pend[0], 2'b00, m_pend[1]};
    endfunction

    function automatic logic exp_irq();
        return m_mie && ((m_pend[0] && m_ie[0]) || (m_pend[1] && m_ie[1]));
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic model_cmp();
        check8("R2 status A vs model", rr0_a_o, exp_rr0(0));
        check8("R2 status B vs model", rr0_b_o, exp_rr0(1));
        check8("R10 pending byte vs model", rr3_o, exp_rr3());
        check8("R9 irq vs model", {7'd0, irq_o}, {7'd0, exp_irq()});
    endtask

    // Advance one clock with the model, then compare at the negedge.
    task automatic step();
        for (int c = 0; c < 2; c++) begin
            logic clr;
            clr = wr_en_i && wr_addr_i == 4'd0 && wr_data_i[5:3] == 3'b010 && wr_chan_i == c[0];
            if (m_pend[c]) begin
                if (clr) m_pend[c] = 1'b0;
            end else begin
                m_pend[c] = m_ie[c] && (((m_s2[c] ^ m_snap[c]) & m_en[c]) != 6'd0);
                m_snap[c] = m_s2[c];
            end
            m_s2[c] = m_s1[c];
            m_s1[c] = ext_i[c*6 +: 6];
        end
        if (wr_en_i) begin
            case (wr_addr_i)
                4'd1:  m_ie[wr_chan_i] = wr_data_i[0];
                4'd9:  m_mie = wr_data_i[3];
                4'd15: m_en[wr_chan_i] = {wr_data_i[7:3], wr_data_i[1]};
                default: ;
            endcase
        end
        @(posedge clk_i);
        @(negedge clk_i);
        model_cmp();
    endtask

    task automatic wr(input logic ch, input logic [3:0] a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_chan_i = ch; wr_addr_i = a; wr_data_i = d;
        step();
        wr_en_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_ni = 1'b0; wr_en_i = 1'b0; wr_chan_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
        ext_i = '0; tx_empty_i = '0; rx_avail_i = '0;
        for (int c = 0; c < 2; c++) begin
            m_s1[c] = '0; m_s2[c] = '0; m_snap[c] = '0; m_pend[c] = 1'b0;
            m_en[c] = '0; m_ie[c] = 1'b0;
        end
        m_mie = 1'b0;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;

        // R1 reset state
        check8("R1 status A after reset", rr0_a_o, 8'h00);
        check8("R1 status B after reset", rr0_b_o, 8'h00);
        check8("R1 pending after reset", rr3_o, 8'h00);
        check8("R1 irq after reset", {7'd0, irq_o}, 8'h00);

        // R3 live bits pass through, never interrupt
        wr(1'b0, 4'd15, 8'hFF);
        wr(1'b0, 4'd1, 8'h01);
        wr(1'b0, 4'd9, 8'h08);
        tx_empty_i[0] = 1'b1; rx_avail_i[0] = 1'b1;
        #1;
        check8("R3 live bits visible same cycle", rr0_a_o, 8'h05);
        idle(4);
        tx_empty_i[0] = 1'b0;
        idle(4);
        check8("R3 live bits raise nothing", rr3_o, 8'h00);
        tx_empty_i[0] = 1'b1;

        // R11 / R4 / R2: CTS rises on channel A
        ext_i[3] = 1'b1;
        step(); step();
        check8("R11 not visible after two edges", rr3_o, 8'h00);
        step();
        check8("R11 pending on third edge", rr3_o, 8'h08);
        check8("R2 CTS at bit 5", rr0_a_o, 8'h25);
        check8("R4 irq on rising CTS", {7'd0, irq_o}, 8'h01);

        // R6 frozen while pending
        ext_i[1] = 1'b1; ext_i[3] = 1'b0;
        idle(5);
        check8("R6 snapshot frozen", rr0_a_o, 8'h25);

        // R7 other command, other channel, then real reset
        wr(1'b0, 4'd0, 8'h38);
        check8("R7 other command keeps pending", rr3_o, 8'h08);
        wr(1'b1, 4'd0, 8'h10);
        check8("R7 command to B keeps A pending", rr3_o, 8'h08);
        wr(1'b0, 4'd0, 8'h10);
        check8("R7 reset clears pending", rr3_o, 8'h00);
        step();
        check8("R7 re-raise on differing snapshot", rr3_o, 8'h08);
        check8("R2 DCD at bit 3", rr0_a_o, 8'h0D);
        wr(1'b0, 4'd0, 8'h10);
        idle(3);
        check8("R7 no re-raise when equal", rr3_o, 8'h00);

        // R4 falling edge
        ext_i[1] = 1'b0;
        idle(3);
        check8("R4 falling DCD raises", rr3_o, 8'h08);
        wr(1'b0, 4'd0, 8'h10);

        // R5 disabled source tracks but stays quiet; bits 2,0 ignored
        wr(1'b0, 4'd15, 8'h20);
        ext_i[1] = 1'b1;
        idle(4);
        check8("R5 disabled DCD no request", rr3_o, 8'h00);
        check8("R5 disabled DCD still tracked", rr0_a_o, 8'h0D);
        wr(1'b0, 4'd15, 8'h05);
        ext_i[3] = 1'b1; ext_i[0] = 1'b1;
        idle(4);
        check8("R5 bits 2 and 0 enable nothing", rr3_o, 8'h00);

        // R8 channel enable off
        wr(1'b0, 4'd15, 8'hFA);
        wr(1'b0, 4'd1, 8'h00);
        ext_i[0] = 1'b0;
        idle(4);
        check8("R8 channel disabled no request", rr3_o, 8'h00);
        check8("R8 zero count tracked at bit 1", rr0_a_o, 8'h2D);
        wr(1'b0, 4'd1, 8'h01);

        // R9 shared master enable, channel B at bit 0
        wr(1'b1, 4'd15, 8'h80);
        wr(1'b1, 4'd1, 8'h01);
        wr(1'b1, 4'd9, 8'h00);
        ext_i[11] = 1'b1;
        idle(3);
        check8("R10 channel B at bit 0", rr3_o, 8'h01);
        check8("R9 master off blocks irq", {7'd0, irq_o}, 8'h00);
        wr(1'b0, 4'd9, 8'h08);
        check8("R9 master via A enables irq", {7'd0, irq_o}, 8'h01);
        wr(1'b1, 4'd0, 8'h10);
        idle(2);

        // random run against the model
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(7) == 0) ext_i[$urandom_range(11)] ^= 1'b1;
            tx_empty_i = 2'($urandom_range(3));
            rx_avail_i = 2'($urandom_range(3));
            if ($urandom_range(9) == 0) begin
                logic       ch;
                logic [7:0] d;
                ch = 1'($urandom_range(1));
                d  = 8'($urandom_range(255));
                case ($urandom_range(5))
                    0, 1, 2: wr(ch, 4'd0, 8'h10);
                    3:       wr(ch, 4'd15, d);
                    4:       wr(ch, 4'd1, {7'd0, ($urandom_range(3) != 0)});
                    default: wr(ch, 4'd9, ($urandom_range(3) != 0) ? 8'h08 : 8'h00);
                endcase
            end else begin
                step();
            end
        end

        summary();
        $finish;
    end
endmodule